// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns the reset causes of a small microcontroller into one clean internal reset. The causes are a power-up reset, an asynchronous active-low external reset pad, a watchdog expiry and a wake-up from stop mode. The pad input passes through a synchronizer and a clock-counting glitch filter. A low level that is too short is dropped. A low level that lasts long enough starts a reset that lasts a minimum number of clocks, and it lasts longer if the pad stays low.

For power-up and watchdog causes, the block pulls the shared reset pad low through an open-drain enable for a configured number of clocks. The same time also bounds the internal reset. While reset is active, the data strobe is held low and the address strobe follows the clock. After release, a fixed wait of a few clocks runs. Then a one-cycle fetch pulse presents the reset vector to the core. A stop-mode wake-up raises a keep flag, which tells the core to preserve its mode and port-configuration registers. A full-reset cause arriving in the same episode overrides that flag.

Top module: `rst_sequencer`

## Requirements
- R1: A synchronized pad low level seen at FILT_LEN (4) or fewer consecutive clock edges causes no reset: `rst_core` stays 0.
- R2: A pad low level seen at FILT_LEN+1 (5) consecutive edges raises `rst_core`. If the pad is released early, `rst_core` stays high for exactly HOLD_CYCLES (18) clocks.
- R3: When the pad stays low for L samples, with L of at least FILT_LEN+1, `rst_core` stays high for max(HOLD_CYCLES, L-4) clocks. It falls two edges after the first high pad sample.
- R4: A watchdog expiry raises `pad_pull_lo` for exactly POR_CYCLES clocks, starting at the edge that samples it. `rst_core` is held for those same POR_CYCLES clocks, or for HOLD_CYCLES if that is longer. `pad_pull_lo` rises on no other event.
- R5: While `por_n` is low, `rst_core`=1, `pad_pull_lo`=1, `ds_n`=0, `fetch_go`=0 and `keep_cfg`=0. After `por_n` rises, pad drive and reset end together at the POR_CYCLES-th edge.
- R6: While `rst_core` is 1, `ds_n` is 0 and `as_n` equals the clock (low in the low half-period). While `rst_core` is 0, both are 1.
- R7: `fetch_go` is a one-cycle pulse. It rises REL_DELAY (6) edges after `rst_core` falls, and `fetch_addr` then holds 12'h00C.
- R8: A stop-mode wake-up alone gives an HOLD_CYCLES reset without pad drive. `keep_cfg` is 1 throughout it and is 0 whenever `rst_core` is 0.
- R9: A watchdog or pad reset in the same cycle as a stop-mode wake-up, or during its reset, leaves `keep_cfg`=0 by the end of the episode. A wake-up inside a full reset does not set `keep_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| ext_rst_n | input | 1 | Reset pad level, active low, asynchronous |
| wdt_expire | input | 1 | Watchdog expiry, one-cycle pulse |
| smr_event | input | 1 | Stop-mode wake-up, one-cycle pulse |
| rst_core | output | 1 | Internal reset to the core, active high |
| pad_pull_lo | output | 1 | Open-drain enable: 1 pulls the reset pad low |
| ds_n | output | 1 | Data strobe, held low during reset |
| as_n | output | 1 | Address strobe, follows the clock during reset |
| fetch_go | output | 1 | One-cycle start pulse for the core |
| fetch_addr | output | VEC_W | Reset vector, valid with `fetch_go` |
| keep_cfg | output | 1 | Preserve mode and port-configuration registers |

## Verification
The bench probes the filter on both sides of its threshold, with 4-sample and 5-sample pad pulses. A filter that is off by one either resets on a 4-sample glitch or misses the 5-sample pulse. Long pad pulses of 21 and 40 samples separate a design that ignores the pad level, whose reset ends after 18 clocks, from one that forgets the minimum, whose reset is too short. Watchdog and wake-up events are mixed in the same cycle and in overlapping order. A design with the wrong priority would report a preserving reset after a full one. Each episode's reset length, pad drive length, release-to-fetch gap and vector are compared against values the bench computes on its own.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

   typedef enum logic [1:0] {
      SEQ_HOLD  = 2'd0,
      SEQ_WAIT  = 2'd1,
      SEQ_FETCH = 2'd2,
      SEQ_RUN   = 2'd3
   } seq_state_t;

   // bits needed to hold values 0..maxv
   function automatic int unsigned cnt_w(input int unsigned maxv);
      return (maxv < 2) ? 1 : $clog2(maxv + 1);
   endfunction

endpackage

// File: rtl/rstseq_glitch_filter.sv
`timescale 1ns/1ps
module rstseq_glitch_filter
   import rstseq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_in_n,
   input  logic mask,
   output logic ext_hi,
   output logic latch_req
);

   localparam int unsigned CW = cnt_w(FILT_LEN + 1);
   localparam logic [CW-1:0] SAT = CW'(FILT_LEN + 1);
   localparam logic [CW-1:0] LIM = CW'(FILT_LEN);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;

   // synchronizer chain, one flop per stage
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= pad_in_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign ext_hi = sync_q[SYNC_STAGES-1];

   // counts consecutive low samples; saturates once a reset was taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (mask)       run_q <= SAT;
      else if (ext_hi)     run_q <= '0;
      else if (run_q != SAT) run_q <= run_q + 1'b1;
   end

   assign latch_req = !ext_hi && (run_q == LIM) && !mask;

   // R2: a low episode yields one latch request only
   assert_latch_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      latch_req |=> !latch_req);

endmodule

// File: rtl/rstseq_pad_timer.sv
`timescale 1ns/1ps
module rstseq_pad_timer
   import rstseq_pkg::*;
#(
   parameter int unsigned POR_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wdt_hit,
   output logic pad_busy,
   output logic pad_ending
);

   localparam int unsigned PW = cnt_w(POR_CYCLES);
   localparam logic [PW-1:0] LOAD = PW'(POR_CYCLES);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= LOAD;
      else if (wdt_hit)      left_q <= LOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign pad_busy   = (left_q != '0);
   assign pad_ending = (left_q <= PW'(1));

   // R4: pad drive starts only from a watchdog expiry after power-up
   assert_pad_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_busy) |-> $past(wdt_hit));

endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/1ps
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 18,
   parameter int unsigned REL_DELAY   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic full_hit,
   input  logic smr_hit,
   input  logic ext_hi,
   input  logic pad_busy,
   input  logic pad_ending,
   output logic rst_active,
   output logic keep_cfg,
   output logic fetch_go
);

   localparam int unsigned HW = cnt_w(HOLD_CYCLES);
   localparam int unsigned RW = cnt_w(REL_DELAY);
   localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);
   localparam logic [RW-1:0] REL_LAST  = RW'(REL_DELAY - 1);

   seq_state_t    state_q;
   logic [HW-1:0] hold_q;
   logic [RW-1:0] rel_q;
   logic          keep_q;
   logic          any_hit;
   logic          hold_done;
   logic          may_release;

   assign any_hit     = full_hit | smr_hit;
   assign hold_done   = (hold_q == HOLD_LAST);
   assign may_release = hold_done & ext_hi & pad_ending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_HOLD;
         hold_q  <= '0;
         rel_q   <= '0;
         keep_q  <= 1'b0;
      end else if (any_hit) begin
         state_q <= SEQ_HOLD;
         hold_q  <= '0;
         // a full cause always clears; inside a running reset the old flag survives only if set
         keep_q  <= ~full_hit & ((state_q == SEQ_HOLD) ? keep_q : 1'b1);
      end else begin
         unique case (state_q)
            SEQ_HOLD: begin
               if (may_release) begin
                  state_q <= SEQ_WAIT;
                  rel_q   <= '0;
                  keep_q  <= 1'b0;
               end else if (!hold_done) begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            SEQ_WAIT: begin
               if (rel_q == REL_LAST) state_q <= SEQ_FETCH;
               else                   rel_q   <= rel_q + 1'b1;
            end
            SEQ_FETCH: state_q <= SEQ_RUN;
            default: ;
         endcase
      end
   end

   assign rst_active = (state_q == SEQ_HOLD);
   assign fetch_go   = (state_q == SEQ_FETCH);
   assign keep_cfg   = keep_q;

   // R3: reset only ends when the synchronized pad was high
   assert_release_pad_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_active) |-> $past(ext_hi));

   // R4: reset never ends while the pad is still pulled low
   assert_release_after_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_active) |-> !pad_busy);

   // R7: the start pulse lasts a single cycle
   assert_fetch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_go |=> !fetch_go);

   // R8: the keep flag only accompanies an active reset
   assert_keep_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      keep_cfg |-> rst_active);

endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
module rst_sequencer
   import rstseq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4,
   parameter int unsigned HOLD_CYCLES = 18,
   parameter int unsigned REL_DELAY   = 6,
   parameter int unsigned POR_CYCLES  = 1_000_000,
   parameter int unsigned VEC_W       = 12,
   parameter logic [VEC_W-1:0] RESET_VEC = 'h00C,
   parameter bit          AS_HALF_CLK = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             ext_rst_n,
   input  logic             wdt_expire,
   input  logic             smr_event,
   output logic             rst_core,
   output logic             pad_pull_lo,
   output logic             ds_n,
   output logic             as_n,
   output logic             fetch_go,
   output logic [VEC_W-1:0] fetch_addr,
   output logic             keep_cfg
);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_sequencer: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("rst_sequencer: FILT_LEN must be at least 1");
   end
   if (HOLD_CYCLES < 1 || REL_DELAY < 1 || POR_CYCLES < 1) begin : g_bad_time
      $error("rst_sequencer: HOLD_CYCLES, REL_DELAY and POR_CYCLES must be positive");
   end
   if (VEC_W < 4) begin : g_bad_vec
      $error("rst_sequencer: VEC_W too narrow for the reset vector");
   end

   logic ext_hi;
   logic latch_req;
   logic pad_busy;
   logic pad_ending;
   logic full_hit;

   rstseq_glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
   ) u_filter (
      .clk       (clk),
      .rst_n     (por_n),
      .pad_in_n  (ext_rst_n),
      .mask      (pad_busy),
      .ext_hi    (ext_hi),
      .latch_req (latch_req)
   );

   rstseq_pad_timer #(
      .POR_CYCLES (POR_CYCLES)
   ) u_pad (
      .clk        (clk),
      .rst_n      (por_n),
      .wdt_hit    (wdt_expire),
      .pad_busy   (pad_busy),
      .pad_ending (pad_ending)
   );

   assign full_hit = latch_req | wdt_expire;

   rstseq_ctrl #(
      .HOLD_CYCLES (HOLD_CYCLES),
      .REL_DELAY   (REL_DELAY)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (por_n),
      .full_hit   (full_hit),
      .smr_hit    (smr_event),
      .ext_hi     (ext_hi),
      .pad_busy   (pad_busy),
      .pad_ending (pad_ending),
      .rst_active (rst_core),
      .keep_cfg   (keep_cfg),
      .fetch_go   (fetch_go)
   );

   assign pad_pull_lo = pad_busy;
   assign ds_n        = ~rst_core;
   assign fetch_addr  = fetch_go ? RESET_VEC : '0;

   // address strobe during reset: clock-following or registered toggle
   if (AS_HALF_CLK) begin : g_as_half
      assign as_n = rst_core ? clk : 1'b1;
   end else begin : g_as_tog
      logic tog_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) tog_q <= 1'b0;
         else        tog_q <= rst_core ? ~tog_q : 1'b0;
      end
      assign as_n = rst_core ? tog_q : 1'b1;
   end

endmodule

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;

   localparam int unsigned POR  = 30;
   localparam int unsigned HOLD = 18;
   localparam int unsigned REL  = 6;
   localparam logic [11:0] VEC  = 12'h00C;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        ext_rst_n = 1'b1;
   logic        wdt_expire = 1'b0;
   logic        smr_event = 1'b0;
   logic        rst_core, pad_pull_lo, ds_n, as_n, fetch_go, keep_cfg;
   logic [11:0] fetch_addr;

   always #2.5 clk = ~clk;

   rst_sequencer #(
      .POR_CYCLES (POR)
   ) u_rst_sequencer (
      .clk        (clk),
      .por_n      (por_n),
      .ext_rst_n  (ext_rst_n),
      .wdt_expire (wdt_expire),
      .smr_event  (smr_event),
      .rst_core   (rst_core),
      .pad_pull_lo(pad_pull_lo),
      .ds_n       (ds_n),
      .as_n       (as_n),
      .fetch_go   (fetch_go),
      .fetch_addr (fetch_addr),
      .keep_cfg   (keep_cfg)
   );

   int runs = 0;
   int fails = 0;

   typedef struct {
      int    rlen;
      bit    keep;
      int    plen;
      string tag;
   } exp_t;
   exp_t expq[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      runs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
   endtask

   // ---------------- monitor / scoreboard ----------------
   int episodes = 0;
   int rises = 0;
   int rlen = 0, plen = 0, gap = 0;
   bit keep_last = 0, prev_rst = 1, gap_on = 0, prev_fetch = 0;

   always @(negedge clk) begin
      if (por_n) begin
         if (rst_core && !prev_rst) rises++;
         if (rst_core) begin
            rlen++;
            keep_last = keep_cfg;
         end
         if (pad_pull_lo) plen++;
         if (!rst_core && prev_rst) begin
            gap_on = 1;
            gap = 0;
         end
         if (!rst_core && keep_cfg) check(0, "R8 keep_cfg outside reset", 1, 0);
         if (prev_fetch) check(!fetch_go, "R7 fetch pulse width", int'(fetch_go), 0);
         if (fetch_go) begin
            if (expq.size() == 0) begin
               check(0, "R7 unexpected fetch pulse", 1, 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(rlen == e.rlen, {e.tag, " reset length"}, rlen, e.rlen);
               check(keep_last == e.keep, {e.tag, " R8 keep flag at end"}, int'(keep_last), int'(e.keep));
               check(plen == e.plen, {e.tag, " R4 pad drive length"}, plen, e.plen);
               check(gap == REL, {e.tag, " R7 release to fetch"}, gap, REL);
               check(fetch_addr == VEC, {e.tag, " R7 vector"}, int'(fetch_addr), int'(VEC));
            end
            rlen = 0; plen = 0; keep_last = 0; gap_on = 0;
            episodes++;
         end else if (gap_on && !rst_core) begin
            gap++;
         end
         prev_rst = rst_core;
         prev_fetch = fetch_go;
      end
   end

   // ---------------- driver ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic ext_pulse(input int n);
      @(negedge clk); #1 ext_rst_n = 1'b0;
      repeat (n) @(negedge clk);
      #1 ext_rst_n = 1'b1;
   endtask

   task automatic pulse(input bit w, input bit s);
      @(negedge clk); #1;
      wdt_expire = w;
      smr_event  = s;
      @(negedge clk); #1;
      wdt_expire = 1'b0;
      smr_event  = 1'b0;
   endtask

   task automatic wait_done(input int target);
      for (int k = 0; k < 400 && episodes < target; k++) @(negedge clk);
      tick(3);
      check(episodes == target, "R7 episode completed", episodes, target);
   endtask

   task automatic push(input int r, input bit k, input int p, input string t);
      exp_t e;
      e.rlen = r; e.keep = k; e.plen = p; e.tag = t;
      expq.push_back(e);
   endtask

   initial begin
      int r0;
      tick(3);
      // R5: state while power-up reset is held
      check(rst_core == 1, "R5 rst_core in reset", int'(rst_core), 1);
      check(pad_pull_lo == 1, "R5 pad drive in reset", int'(pad_pull_lo), 1);
      check(ds_n == 0, "R5 ds_n in reset", int'(ds_n), 0);
      check(fetch_go == 0, "R5 fetch_go in reset", int'(fetch_go), 0);
      check(keep_cfg == 0, "R5 keep_cfg in reset", int'(keep_cfg), 0);
      push(POR - 1, 0, POR - 1, "R5");
      @(negedge clk); #1 por_n = 1'b1;
      wait_done(1);

      // R6: strobes idle while running
      @(posedge clk); #1.25 check(as_n == 1, "R6 as_n idle high phase", int'(as_n), 1);
      @(negedge clk); #1.25 check(as_n == 1, "R6 as_n idle low phase", int'(as_n), 1);
      check(ds_n == 1, "R6 ds_n idle", int'(ds_n), 1);

      // R1: short glitches are dropped
      r0 = rises;
      ext_pulse(4);
      tick(30);
      check(rises == r0, "R1 4-sample glitch", rises - r0, 0);
      ext_pulse(1);
      tick(30);
      check(rises == r0 && rst_core == 0, "R1 1-sample glitch", rises - r0, 0);

      // R2: 5 samples latch a minimum-length reset; R6 strobes during it
      push(HOLD, 0, 0, "R2");
      ext_pulse(5);
      for (int k = 0; k < 20 && !rst_core; k++) @(negedge clk);
      @(posedge clk); #1.25 check(as_n == 1, "R6 as_n high phase in reset", int'(as_n), 1);
      @(negedge clk); #1.25 check(as_n == 0, "R6 as_n low phase in reset", int'(as_n), 0);
      check(ds_n == 0, "R6 ds_n in reset", int'(ds_n), 0);
      wait_done(2);

      // R3: reset extended by a long pad low, and minimum kept for a medium one
      push(36, 0, 0, "R3 long");
      ext_pulse(40);
      wait_done(3);
      push(HOLD, 0, 0, "R3 medium");
      ext_pulse(21);
      wait_done(4);

      // R4: watchdog drives the pad
      push(POR, 0, POR, "R4");
      pulse(1, 0);
      wait_done(5);

      // R8: stop-mode wake-up keeps configuration
      push(HOLD, 1, 0, "R8");
      pulse(0, 1);
      wait_done(6);

      // R9: simultaneous causes
      push(POR, 0, POR, "R9 same cycle");
      pulse(1, 1);
      wait_done(7);

      // R9: watchdog during a wake-up reset
      push(35, 0, POR, "R9 wdt after wake");
      pulse(0, 1);
      repeat (3) @(negedge clk);
      pulse(1, 0);
      wait_done(8);

      // R9: wake-up during a watchdog reset
      push(POR, 0, POR, "R9 wake after wdt");
      pulse(1, 0);
      repeat (3) @(negedge clk);
      pulse(0, 1);
      wait_done(9);

      tick(10);
      check(expq.size() == 0, "R7 all expected episodes seen", expq.size(), 0);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      runs++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", episodes, 9);
      summary();
      $finish;
   end

endmodule